// File: doc/BRIEF.md
# OR/XOR accumulate register

A parameterised word register made of identical one-bit cells. Each cell can do one of two things with its stored bit and the matching bit of an external input word. It can OR that bit in (accumulate: the bit is set and stays set). It can XOR it in (toggle). The choice comes from two control inputs, one for each operation. When neither control is high, the cell keeps its bit.

The register is clocked on every edge and the clock is never gated. A load enable is formed from the two controls. When that enable is low, a multiplexer routes each flop's own output back to its input, so the value is held. A typical use is a sticky flag word that collects events through the OR path and clears or flips chosen bits through the XOR path.

The controls are decoded once and shared by all cells. Each cell's next value depends only on its own stored bit, its own input bit and those shared controls.

Top module: `orx_reg_array`

## Requirements
- R1: While `rst_ni` is low, `a_o` is all zeros, and the clear takes effect without waiting for a clock edge. It overrides both controls.
- R2: With `or_en_i`=1 and `xor_en_i`=0, `a_o` becomes `a_o | b_i` (bitwise) at the next rising edge of `clk_i`.
- R3: With `xor_en_i`=1 and `or_en_i`=0, `a_o` becomes `a_o ^ b_i` (bitwise) at the next rising edge.
- R4: With both controls at 0, `a_o` keeps its value across the edge whatever `b_i` holds. The hold is done by feeding the flop output back through a multiplexer, and the clock is not gated.
- R5: With both controls at 1, which is not a normal operation, the OR result is taken: `a_o` becomes `a_o | b_i`.
- R6: Bit i of the next value depends only on bit i of `a_o`, bit i of `b_i` and the two controls. A single-bit change in `b_i` affects only that bit position.
- R7: The word width is the parameter `WIDTH` (default 8), and every rule above holds for every bit at any width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the register |
| b_i | input | WIDTH | Operand word combined into the register |
| or_en_i | input | 1 | Selects OR-accumulate at the next edge |
| xor_en_i | input | 1 | Selects XOR-toggle at the next edge |
| a_o | output | WIDTH | Parallel register contents |

## Verification
The bench builds the block with `WIDTH` = 12. This width is not a power of two and differs from the default, so any hidden reliance on eight bits in the cell array or the word-level checks would show up. The 12-bit width also lets walking-one patterns reach every bit position, which tests that each bit is independent of the others. Random control and data sequences, including the both-high case and a reset applied in the middle of a run, are compared every cycle against a behavioural model of the previous word.

// File: rtl/orx_pkg.sv
package orx_pkg;
  typedef enum logic {
    OP_OR  = 1'b0,
    OP_XOR = 1'b1
  } orx_op_e;
endpackage

// File: rtl/orx_ctrl.sv
module orx_ctrl
  import orx_pkg::*;
(
  input  logic    or_en_i,
  input  logic    xor_en_i,
  output logic    load_o,
  output orx_op_e op_o
);
  assign load_o = or_en_i | xor_en_i;
  // OR wins when both are high
  assign op_o   = or_en_i ? OP_OR : OP_XOR;
endmodule

// File: rtl/orx_cell.sv
module orx_cell
  import orx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_i,
  input  orx_op_e op_i,
  input  logic    b_i,
  output logic    q_o
);
  logic q_q, op_res, d;

  always_comb begin
    unique case (op_i)
      OP_OR:   op_res = q_q | b_i;
      default: op_res = q_q ^ b_i;
    endcase
  end

  // feedback mux keeps the value when not loading
  assign d = load_i ? op_res : q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= d;
  end

  assign q_o = q_q;

  AST_CELL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o)); // R4
endmodule

// File: rtl/orx_reg_array.sv
module orx_reg_array
  import orx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] b_i,
  input  logic             or_en_i,
  input  logic             xor_en_i,
  output logic [WIDTH-1:0] a_o
);
  logic    load;
  orx_op_e op;

  orx_ctrl u_ctrl (
    .or_en_i (or_en_i),
    .xor_en_i(xor_en_i),
    .load_o  (load),
    .op_o    (op)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    orx_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load),
      .op_i  (op),
      .b_i   (b_i[i]),
      .q_o   (a_o[i])
    );
  end

  // first edge after reset has a valid $past
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (a_o == '0)); // R1
  AST_OR_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(or_en_i) && !$past(xor_en_i))
      |-> a_o == ($past(a_o) | $past(b_i))); // R2
  AST_XOR_TGL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(xor_en_i) && !$past(or_en_i))
      |-> a_o == ($past(a_o) ^ $past(b_i))); // R3
  AST_HOLD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(or_en_i) && !$past(xor_en_i))
      |-> a_o == $past(a_o)); // R4
  AST_OR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(or_en_i) && $past(xor_en_i))
      |-> a_o == ($past(a_o) | $past(b_i))); // R5
endmodule

// File: tb/orx_reg_array_test.sv
module orx_reg_array_test;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] b;
  logic         cx, cy;
  logic [W-1:0] a;
  logic [W-1:0] model;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  orx_reg_array #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .b_i(b),
    .or_en_i(cx), .xor_en_i(cy), .a_o(a)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (a !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, a, exp);
    end
  endtask

  // drive at negedge, clock once, compare at following negedge
  task automatic step(input logic [W-1:0] bv, input logic x, input logic y,
                      input string req);
    b = bv; cx = x; cy = y;
    if (x)      model = model | bv;  // OR covers R2 and priority R5
    else if (y) model = model ^ bv;
    @(posedge clk);
    @(negedge clk);
    check(req, model);
  endtask

  function automatic string tag(input logic x, input logic y);
    if (x && y) return "R5";
    if (x)      return "R2";
    if (y)      return "R3";
    return "R4";
  endfunction

  initial begin
    rst_n = 1'b0; b = '1; cx = 1'b1; cy = 1'b0; model = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", '0);
    rst_n = 1'b1;
    step(12'h0F0, 1'b0, 1'b0, "R4 hold after reset");
    step(12'h0F0, 1'b1, 1'b0, "R2 or");
    step(12'h303, 1'b1, 1'b0, "R2 or accumulate");
    step(12'h0FF, 1'b0, 1'b1, "R3 xor");
    step(12'hFFF, 1'b0, 1'b0, "R4 hold ones");
    step(12'hA5A, 1'b1, 1'b1, "R5 both high");
    step(model,   1'b0, 1'b1, "R3 xor to zero");
    for (int i = 0; i < W; i++)
      step(W'(1) << i, 1'b0, 1'b1, "R6 walking one set R7");
    for (int i = 0; i < W; i += 2)
      step(W'(1) << i, 1'b0, 1'b1, "R6 walking one clear");
    for (int i = 0; i < 400; i++) begin
      logic x, y;
      x = 1'($urandom);
      y = 1'($urandom);
      step(W'($urandom), x, y, tag(x, y));
    end
    // asynchronous clear between edges
    #1 rst_n = 1'b0;
    #1 model = '0;
    check("R1 async clear", '0);
    b = '1; cx = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 override", '0);
    rst_n = 1'b1;
    step(12'h811, 1'b1, 1'b0, "R2 after reset");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule